// File: doc/BRIEF.md
# Telephone Ring Detect Controller

This block turns two comparator flags taken from the ring pair into status, a ring-present indication, an interrupt and a stream of 16-bit ring samples. One flag is high while the ring-pair voltage is above the positive threshold. The other is high while the voltage is below the negative threshold. Both flags are brought into the clock domain through two flops. The synchronized flags appear directly as live polarity status bits. Their rising edges are the candidate ring events.

A mode input chooses which excursions count as ring events. In half-wave mode only positive excursions count. In full-wave mode both positive and negative excursions count. Each counted event sets a ring-present flag and reloads a countdown. If the countdown runs out with no new event, the flag clears. Going off-hook clears the flag at once. A masked interrupt fires when the flag rises and stays high until software clears it.

While the serial link is powered and the line is neither off-hook nor in on-hook monitoring, the block also produces a sample that follows the ring cadence. This sample uses full-scale codes, and the codes depend on the mode.

Top module: `ring_detect_ctrl`

## Requirements
- R1: `pos_stat_o` follows `cmp_pos_i` and `neg_stat_o` follows `cmp_neg_i` through a two-flop synchronizer. Each status output shows its input value from two clock edges earlier.
- R2: A ring event is a rising edge of a synchronized flag. With `full_wave_i`=0, only rising edges of the positive flag count. With `full_wave_i`=1, rising edges of either flag count.
- R3: A counted event sets `ring_present_o` on the following edge and loads a countdown of HOLD_CYCLES. The flag stays high for HOLD_CYCLES cycles after the last event, so any new event restarts the full hold.
- R4: While `off_hook_i` is 1, `ring_present_o` is forced to 0 on the next edge and events are ignored.
- R5: When the mask bit is 1, a 0-to-1 change of `ring_present_o` sets `irq_o` (active high). The mask bit is written through `mask_wr_i`/`mask_data_i`. `irq_o` then stays high after the flag falls.
- R6: `irq_clr_i` clears `irq_o`. If a masked flag rise occurs in the same cycle as the clear, the set wins and `irq_o` stays 1.
- R7: `sample_vld_o` is 1, and ring samples drive `sample_o`, only when `link_pd_i`, `off_hook_i` and `line_mon_i` are all 0. Otherwise `sample_o` is 16'h0000 and `sample_vld_o` is 0.
- R8: In half-wave mode, `sample_o` is 16'h7FFF while the synchronized positive flag is high. Otherwise it is 16'h8000.
- R9: In full-wave mode, `sample_o` is 16'h7FFF while positive, 16'h8000 while negative, and 16'h04CC (+1228) between the thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_pos_i | input | 1 | Ring voltage above positive threshold (asynchronous) |
| cmp_neg_i | input | 1 | Ring voltage below negative threshold (asynchronous) |
| full_wave_i | input | 1 | 1 = full-wave detection, 0 = half-wave |
| off_hook_i | input | 1 | Line is off-hook |
| line_mon_i | input | 1 | On-hook line monitor mode active |
| link_pd_i | input | 1 | Serial link powered down |
| mask_wr_i | input | 1 | Write strobe for the interrupt mask bit |
| mask_data_i | input | 1 | Mask value written on `mask_wr_i` |
| irq_clr_i | input | 1 | Clears the pending interrupt |
| pos_stat_o | output | 1 | Synchronized positive status |
| neg_stat_o | output | 1 | Synchronized negative status |
| ring_present_o | output | 1 | Retriggerable ring-present flag |
| irq_o | output | 1 | Ring interrupt, level-held |
| sample_o | output | 16 | Ring sample code |
| sample_vld_o | output | 1 | Sample owns the serial data |

## Verification
On every cycle, the assertions check the following:
- off-hook forces the ring-present flag low on the next edge;
- every unblocked event sets the flag;
- the flag only falls after a terminal count or an off-hook;
- a rise of `irq_o` always traces back to a masked flag rise;
- half-wave samples only take the two full-scale codes.

Some behaviours can only be shown by the bench's scenarios. These are:
- the exact hold length, and its restart when a second event arrives mid-hold;
- a negative pulse being ignored in half-wave mode;
- the clear-versus-set collision;
- the complete code table across every ownership combination.

// File: rtl/ring_detect_pkg.sv
package ring_detect_pkg;

  localparam int SAMPLE_W = 16;

  localparam logic [SAMPLE_W-1:0] CODE_POS_FS  = 16'h7FFF;
  localparam logic [SAMPLE_W-1:0] CODE_NEG_FS  = 16'h8000;
  localparam logic [SAMPLE_W-1:0] CODE_FW_IDLE = 16'h04CC;
  localparam logic [SAMPLE_W-1:0] CODE_NONE    = 16'h0000;

  // Sample code for a given mode and polarity; positive wins if both are set.
  function automatic logic [SAMPLE_W-1:0] ring_code(input logic fw,
                                                    input logic pos,
                                                    input logic neg);
    if (pos)      return CODE_POS_FS;
    else if (neg) return CODE_NEG_FS;
    else if (fw)  return CODE_FW_IDLE;
    else          return CODE_NEG_FS;
  endfunction

  // Whether a rising edge on either polarity counts as a ring event.
  function automatic logic ring_qualify(input logic fw,
                                        input logic pos_rise,
                                        input logic neg_rise);
    return pos_rise | (fw & neg_rise);
  endfunction

endpackage

// File: rtl/rd_sync.sv
module rd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/rd_oneshot.sv
module rd_oneshot #(
  parameter int HOLD_CYCLES = 625_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic kill_i,
  output logic flag_o,
  output logic rise_o
);

  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          flag_q;
  logic          terminal;

  assign terminal = flag_q && (cnt_q == ONE);
  assign rise_o   = trig_i && !kill_i && !flag_q;
  assign flag_o   = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (kill_i) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (trig_i) begin
      flag_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (terminal) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (flag_q) begin
      cnt_q  <= cnt_q - ONE;
    end
  end

  assert_offhook_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> !flag_q);

  assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !kill_i) |=> flag_q);

  assert_fall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> ($past(kill_i) || $past(cnt_q) == ONE));

endmodule

// File: rtl/rd_sample_enc.sv
module rd_sample_enc
  import ring_detect_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                own_i,
  input  logic                fw_i,
  input  logic                pos_i,
  input  logic                neg_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                vld_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_o <= CODE_NONE;
      vld_o    <= 1'b0;
    end else begin
      vld_o    <= own_i;
      sample_o <= own_i ? ring_code(fw_i, pos_i, neg_i) : CODE_NONE;
    end
  end

  assert_hw_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !$past(fw_i)) |-> (sample_o == CODE_POS_FS || sample_o == CODE_NEG_FS));

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(own_i) |-> (sample_o == CODE_NONE));

endmodule

// File: rtl/ring_detect_ctrl.sv
module ring_detect_ctrl
  import ring_detect_pkg::*;
#(
  parameter int HOLD_CYCLES = 625_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmp_pos_i,
  input  logic        cmp_neg_i,
  input  logic        full_wave_i,
  input  logic        off_hook_i,
  input  logic        line_mon_i,
  input  logic        link_pd_i,
  input  logic        mask_wr_i,
  input  logic        mask_data_i,
  input  logic        irq_clr_i,
  output logic        pos_stat_o,
  output logic        neg_stat_o,
  output logic        ring_present_o,
  output logic        irq_o,
  output logic [15:0] sample_o,
  output logic        sample_vld_o
);

  logic [1:0] sync_w;
  logic       pos_s, neg_s;
  logic       pos_prev_q, neg_prev_q;
  logic       pos_rise, neg_rise;
  logic       ring_event;
  logic       flag_rise;
  logic       mask_q;
  logic       irq_q;
  logic       sample_own;

  rd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({cmp_neg_i, cmp_pos_i}),
    .sync_o  (sync_w)
  );

  assign pos_s = sync_w[0];
  assign neg_s = sync_w[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_prev_q <= 1'b0;
      neg_prev_q <= 1'b0;
    end else begin
      pos_prev_q <= pos_s;
      neg_prev_q <= neg_s;
    end
  end

  assign pos_rise   = pos_s && !pos_prev_q;
  assign neg_rise   = neg_s && !neg_prev_q;
  assign ring_event = ring_qualify(full_wave_i, pos_rise, neg_rise);

  rd_oneshot #(.HOLD_CYCLES(HOLD_CYCLES)) u_oneshot (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (ring_event),
    .kill_i (off_hook_i),
    .flag_o (ring_present_o),
    .rise_o (flag_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_wr_i) mask_q <= mask_data_i;
      if (flag_rise && mask_q) irq_q <= 1'b1;
      else if (irq_clr_i)      irq_q <= 1'b0;
    end
  end

  assign irq_o      = irq_q;
  assign pos_stat_o = pos_s;
  assign neg_stat_o = neg_s;
  assign sample_own = !link_pd_i && !off_hook_i && !line_mon_i;

  rd_sample_enc u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .own_i    (sample_own),
    .fw_i     (full_wave_i),
    .pos_i    (pos_s),
    .neg_i    (neg_s),
    .sample_o (sample_o),
    .vld_o    (sample_vld_o)
  );

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(flag_rise && mask_q));

  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr_i) |=> irq_q);

  assert_event_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rise && mask_q && irq_clr_i) |=> irq_q);

endmodule

// File: tb/ring_detect_ctrl_tb_top.sv
module ring_detect_ctrl_tb_top;

  localparam int HOLD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_pos = 1'b0, cmp_neg = 1'b0, full_wave = 1'b0;
  logic        off_hook = 1'b0, line_mon = 1'b0, link_pd = 1'b0;
  logic        mask_wr = 1'b0, mask_data = 1'b0, irq_clr = 1'b0;
  logic        pos_stat, neg_stat, ring_present, irq;
  logic [15:0] sample;
  logic        sample_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ring_detect_ctrl #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmp_pos_i(cmp_pos), .cmp_neg_i(cmp_neg), .full_wave_i(full_wave),
    .off_hook_i(off_hook), .line_mon_i(line_mon), .link_pd_i(link_pd),
    .mask_wr_i(mask_wr), .mask_data_i(mask_data), .irq_clr_i(irq_clr),
    .pos_stat_o(pos_stat), .neg_stat_o(neg_stat),
    .ring_present_o(ring_present), .irq_o(irq),
    .sample_o(sample), .sample_vld_o(sample_vld)
  );

  // {pd, off_hook, mon, fw, pos, neg, exp_vld, exp_sample[15:0]}
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {6'b000000, 1'b1, 16'h8000},
    {6'b000010, 1'b1, 16'h7FFF},
    {6'b000001, 1'b1, 16'h8000},
    {6'b000100, 1'b1, 16'h04CC},
    {6'b000110, 1'b1, 16'h7FFF},
    {6'b000101, 1'b1, 16'h8000},
    {6'b100110, 1'b0, 16'h0000},
    {6'b010010, 1'b0, 16'h0000},
    {6'b001101, 1'b0, 16'h0000},
    {6'b000000, 1'b1, 16'h8000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_pos();
    cmp_pos = 1'b1; wait_n(4); cmp_pos = 1'b0;
  endtask

  task automatic pulse_neg();
    cmp_neg = 1'b1; wait_n(4); cmp_neg = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    wait_n(3);
    chk("R3 reset flag", ring_present, 0);
    chk("R5 reset irq", irq, 0);
    chk("R1 reset stat", {pos_stat, neg_stat}, 0);
    rst_n = 1'b1;
    wait_n(3);

    // R1 two-flop latency: visible after two edges, not after one
    cmp_pos = 1'b1;
    wait_n(1);
    chk("R1 pos after 1 edge", pos_stat, 0);
    wait_n(1);
    chk("R1 pos after 2 edges", pos_stat, 1);
    cmp_pos = 1'b0;
    wait_n(3);

    for (int v = 0; v < NV; v++) begin
      {link_pd, off_hook, line_mon, full_wave, cmp_pos, cmp_neg} = VEC[v][22:17];
      wait_n(4);
      chk($sformatf("R7 vld row %0d", v), sample_vld, VEC[v][16]);
      chk($sformatf("R8/R9 sample row %0d", v), sample, VEC[v][15:0]);
      chk($sformatf("R1 stat row %0d", v), {pos_stat, neg_stat}, VEC[v][18:17]);
    end
    {link_pd, off_hook, line_mon, full_wave, cmp_pos, cmp_neg} = '0;
    off_hook = 1'b1; wait_n(2); off_hook = 1'b0; wait_n(2);

    // R3 set, hold and expiry (mask still 0)
    pulse_pos(); wait_n(2);
    chk("R3 set", ring_present, 1);
    chk("R5 masked irq", irq, 0);
    wait_n(30);
    chk("R3 expire", ring_present, 0);

    // R3 retrigger restarts hold
    pulse_pos(); wait_n(11);
    pulse_pos(); wait_n(11);
    chk("R3 retrigger hold", ring_present, 1);
    wait_n(15);
    chk("R3 retrigger expire", ring_present, 0);

    // R2 half-wave ignores negative, full-wave counts it
    full_wave = 1'b0; pulse_neg(); wait_n(2);
    chk("R2 half-wave neg ignored", ring_present, 0);
    full_wave = 1'b1; pulse_neg(); wait_n(2);
    chk("R2 full-wave neg counts", ring_present, 1);
    full_wave = 1'b0;

    // R4 off-hook clears flag and blocks events
    off_hook = 1'b1; wait_n(1);
    chk("R4 off-hook clears", ring_present, 0);
    pulse_pos(); wait_n(2);
    chk("R4 event blocked", ring_present, 0);
    off_hook = 1'b0; wait_n(2);

    // R5 masked interrupt, level-held
    mask_wr = 1'b1; mask_data = 1'b1; wait_n(1); mask_wr = 1'b0;
    pulse_pos(); wait_n(2);
    chk("R5 irq set", irq, 1);
    wait_n(30);
    chk("R5 flag gone", ring_present, 0);
    chk("R5 irq held", irq, 1);

    // R6 clear
    irq_clr = 1'b1; wait_n(1); irq_clr = 1'b0;
    chk("R6 irq cleared", irq, 0);

    // R6 set beats clear in the same cycle
    pulse_pos(); wait_n(30);
    chk("R6 pending before collide", irq, 1);
    cmp_pos = 1'b1;
    wait_n(2);
    irq_clr = 1'b1;
    wait_n(1);
    irq_clr = 1'b0;
    chk("R6 set wins", irq, 1);
    chk("R6 flag set", ring_present, 1);
    cmp_pos = 1'b0;
    wait_n(2);

    done = 1'b1;
    summary();
  end

endmodule